// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block manages one DMA channel for a host processor. The host programs it through 32-bit, word-only registers: a control/status word, a live pair of pointers (next and limit), a reload pair (start and stop), a one-shot initial-buffer pointer and a size word. A device-side strobe reports that a burst of a given byte count has arrived. The block then issues a memory request that carries the burst base address and the byte count rounded up to the channel alignment.

When memory accepts the request, the channel closes out the burst. It records the next pointer and the end of the burst as a saved pair and clears the one-shot pointer. Unless chaining is on, it reloads the live pointers from the reload pair. It then sets the complete flag and raises a single-cycle interrupt.

The parameter `NET_CHAN` selects the alignment: 16 bytes for an ordinary channel and 32 bytes for a network channel. The data movement itself belongs to whatever answers the request handshake.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `dma_irq` and `mem_req` are low.
- R2: A write to `reg_addr` 0x4000 (next), 0x4004 (limit), 0x4008 (start), 0x400C (stop), 0x4200 (initial buffer) or 0x4204 (size) stores the word. A read strobe returns the stored word on `reg_rdata` one cycle later.
- R3: A write to the control word at offset 0x0 acts only on the command bits that are set. Bit 16 sets enable, bit 17 sets chain, bit 18 clears complete and bit 20 sets direction. A control write with no command bits set changes nothing. The status read places enable at bit 0, chain at bit 1, complete at bit 2 and direction at bit 3, with all other bits zero.
- R4: Control bit 19 clears enable, chain, complete and direction together. It takes precedence over any set command in the same write.
- R5: A burst report that arrives while enable is clear is ignored: no request is issued and no interrupt is raised.
- R6: The request address is the initial-buffer pointer when that pointer is nonzero, and the next pointer otherwise. `mem_req` rises in the cycle after the report is sampled.
- R7: `mem_len` is the byte count rounded up to a multiple of 16 (32 when `NET_CHAN` is set). A count of zero stays zero, and the result is one bit wider than the count.
- R8: At the acknowledge edge, saved next takes the current next pointer, saved limit takes next plus `mem_len`, and the initial-buffer pointer is cleared.
- R9: At the acknowledge edge, next is reloaded from start and limit from stop if chain is clear. If chain is set, both are left unchanged.
- R10: Every completed burst sets the complete flag and drives `dma_irq` high for exactly one cycle, starting at the acknowledge edge.
- R11: Reads of any other offset return zero, and writes to any other offset change no register.
- R12: `mem_req`, `mem_addr` and `mem_len` hold steady until `mem_ack`. A burst report arriving during that wait is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset from channel base |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word, valid one cycle after `reg_rd` |
| burst_done | input | 1 | Device reports a finished burst |
| burst_bytes | input | LEN_W | Byte count of the reported burst |
| mem_req | output | 1 | Memory request pending |
| mem_addr | output | 32 | Burst base address |
| mem_len | output | LEN_W+1 | Rounded burst length in bytes |
| mem_ack | input | 1 | Memory accepts the request |
| saved_next | output | 32 | Next pointer recorded at the last completion |
| saved_limit | output | 32 | End of the last completed burst |
| dma_irq | output | 1 | One-cycle completion interrupt |

## Verification
Results fall due at different cycles.

- A register read is due one edge after its strobe.
- A burst report raises the request, with its address and length, at the first edge that samples it.
- The saved pair, reloaded pointers, cleared initial-buffer pointer, complete flag and interrupt all change at the edge that samples `mem_ack`. The interrupt drops again one edge later.

The bench drives every input at a falling edge and samples at the following falling edge, half a period after the register has updated. The interrupt is checked both in the cycle after the acknowledge and in the cycle after that. For ignored reports, the request and interrupt are watched for several cycles.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int OFF_W = 15;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 15'h0000;
  localparam logic [OFF_W-1:0] OFF_NEXT  = 15'h4000;
  localparam logic [OFF_W-1:0] OFF_LIMIT = 15'h4004;
  localparam logic [OFF_W-1:0] OFF_START = 15'h4008;
  localparam logic [OFF_W-1:0] OFF_STOP  = 15'h400C;
  localparam logic [OFF_W-1:0] OFF_INIT  = 15'h4200;
  localparam logic [OFF_W-1:0] OFF_SIZE  = 15'h4204;

  // command bit positions in a control write
  localparam int CMD_EN    = 16;
  localparam int CMD_CHAIN = 17;
  localparam int CMD_CLR   = 18;
  localparam int CMD_RST   = 19;
  localparam int CMD_DIR   = 20;

  // status flags, packed so that en lands on bit 0 of a read
  typedef struct packed {
    logic dir;
    logic done;
    logic chain;
    logic en;
  } ctrl_flags_t;

  typedef enum logic {ENG_IDLE, ENG_REQ} eng_state_e;
endpackage

// File: rtl/dmach_align.sv
module dmach_align #(
  parameter int LEN_W    = 16,
  parameter bit NET_CHAN = 1'b0
) (
  input  logic [LEN_W-1:0] bytes_in,
  output logic [LEN_W:0]   bytes_up
);
  generate
    if (NET_CHAN) begin : g_net
      localparam int SH = 5;
      logic [LEN_W:0] sum;
      assign sum      = {1'b0, bytes_in} + (LEN_W+1)'((1 << SH) - 1);
      assign bytes_up = {sum[LEN_W:SH], {SH{1'b0}}};
    end else begin : g_std
      localparam int SH = 4;
      logic [LEN_W:0] sum;
      assign sum      = {1'b0, bytes_in} + (LEN_W+1)'((1 << SH) - 1);
      assign bytes_up = {sum[LEN_W:SH], {SH{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DATA_W-1:0] next_ptr,
  input  logic [DATA_W-1:0] init_ptr,
  input  logic              burst_done,
  input  logic [LEN_W:0]    len_up,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  output logic [LEN_W:0]    mem_len,
  output logic              cmpl_fire,
  output logic              irq
);
  eng_state_e state;

  assign cmpl_fire = (state == ENG_REQ) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_len  <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (burst_done && enable) begin
            mem_addr <= (init_ptr != '0) ? init_ptr : next_ptr;
            mem_len  <= len_up;
            mem_req  <= 1'b1;
            state    <= ENG_REQ;
          end
        end
        ENG_REQ: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            irq     <= 1'b1;
            state   <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R10
  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mem_req && mem_ack)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len))); // R12
  AST_LEN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_len[ALIGN_LOG2-1:0] == '0)); // R7
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(enable)); // R5
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmpl_fire,
  input  logic [LEN_W:0]    cmpl_len,
  output logic              enable,
  output logic [DATA_W-1:0] next_ptr,
  output logic [DATA_W-1:0] init_ptr,
  output logic [DATA_W-1:0] saved_next,
  output logic [DATA_W-1:0] saved_limit
);
  ctrl_flags_t       fl;
  logic [DATA_W-1:0] limit_r, start_r, stop_r, size_r;
  logic [DATA_W-1:0] rd_mux;
  logic              hit_ctrl, hit_next, hit_limit, hit_start, hit_stop, hit_init, hit_size;

  assign hit_ctrl  = (reg_addr == ADDR_W'(OFF_CTRL));
  assign hit_next  = (reg_addr == ADDR_W'(OFF_NEXT));
  assign hit_limit = (reg_addr == ADDR_W'(OFF_LIMIT));
  assign hit_start = (reg_addr == ADDR_W'(OFF_START));
  assign hit_stop  = (reg_addr == ADDR_W'(OFF_STOP));
  assign hit_init  = (reg_addr == ADDR_W'(OFF_INIT));
  assign hit_size  = (reg_addr == ADDR_W'(OFF_SIZE));

  assign enable = fl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl          <= '0;
      next_ptr    <= '0;
      limit_r     <= '0;
      start_r     <= '0;
      stop_r      <= '0;
      init_ptr    <= '0;
      size_r      <= '0;
      saved_next  <= '0;
      saved_limit <= '0;
    end else begin
      if (reg_wr) begin
        if (hit_ctrl) begin
          if (reg_wdata[CMD_DIR])   fl.dir   <= 1'b1;
          if (reg_wdata[CMD_EN])    fl.en    <= 1'b1;
          if (reg_wdata[CMD_CHAIN]) fl.chain <= 1'b1;
          if (reg_wdata[CMD_CLR])   fl.done  <= 1'b0;
          if (reg_wdata[CMD_RST])   fl       <= '0;
        end
        if (hit_next)  next_ptr <= reg_wdata;
        if (hit_limit) limit_r  <= reg_wdata;
        if (hit_start) start_r  <= reg_wdata;
        if (hit_stop)  stop_r   <= reg_wdata;
        if (hit_init)  init_ptr <= reg_wdata;
        if (hit_size)  size_r   <= reg_wdata;
      end
      // completion takes priority over a host write in the same cycle
      if (cmpl_fire) begin
        saved_next  <= next_ptr;
        saved_limit <= next_ptr + DATA_W'(cmpl_len);
        init_ptr    <= '0;
        fl.done     <= 1'b1;
        if (!fl.chain) begin
          next_ptr <= start_r;
          limit_r  <= stop_r;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)  rd_mux = DATA_W'(fl);
    if (hit_next)  rd_mux = next_ptr;
    if (hit_limit) rd_mux = limit_r;
    if (hit_start) rd_mux = start_r;
    if (hit_stop)  rd_mux = stop_r;
    if (hit_init)  rd_mux = init_ptr;
    if (hit_size)  rd_mux = size_r;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_DONE_ON_CMPL: assert property (@(posedge clk) disable iff (rst)
    cmpl_fire |=> fl.done); // R10
  AST_INIT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    cmpl_fire |=> (init_ptr == '0)); // R8
  AST_RST_CMD: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && hit_ctrl && reg_wdata[CMD_RST] && !cmpl_fire) |=> (fl == '0)); // R4
  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cmpl_fire && fl.chain && !(reg_wr && hit_next)) |=> $stable(next_ptr)); // R9
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int ADDR_W   = 15,
  parameter int LEN_W    = 16,
  parameter bit NET_CHAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              burst_done,
  input  logic [LEN_W-1:0]  burst_bytes,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic [LEN_W:0]    mem_len,
  input  logic              mem_ack,
  output logic [31:0]       saved_next,
  output logic [31:0]       saved_limit,
  output logic              dma_irq
);
  localparam int DATA_W     = 32;
  localparam int ALIGN_LOG2 = NET_CHAN ? 5 : 4;

  logic              enable, cmpl_fire;
  logic [DATA_W-1:0] next_ptr, init_ptr;
  logic [LEN_W:0]    len_up;

  dmach_align #(.LEN_W(LEN_W), .NET_CHAN(NET_CHAN)) u_align (
    .bytes_in(burst_bytes),
    .bytes_up(len_up)
  );

  dmach_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .ALIGN_LOG2(ALIGN_LOG2)) u_engine (
    .clk(clk), .rst(rst), .enable(enable), .next_ptr(next_ptr), .init_ptr(init_ptr),
    .burst_done(burst_done), .len_up(len_up), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .cmpl_fire(cmpl_fire), .irq(dma_irq)
  );

  dmach_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmpl_fire(cmpl_fire),
    .cmpl_len(mem_len), .enable(enable), .next_ptr(next_ptr), .init_ptr(init_ptr),
    .saved_next(saved_next), .saved_limit(saved_limit)
  );
endmodule

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
  localparam int ADDR_W = 15;
  localparam int LEN_W  = 16;
  localparam int NV     = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              burst_done = 1'b0;
  logic [LEN_W-1:0]  burst_bytes = '0;
  logic              mem_req, mem_ack = 1'b0, dma_irq;
  logic [31:0]       mem_addr, saved_next, saved_limit;
  logic [LEN_W:0]    mem_len;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_chan_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NET_CHAN(1'b0)) i_dma_chan_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .burst_done(burst_done),
    .burst_bytes(burst_bytes), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_ack(mem_ack), .saved_next(saved_next),
    .saved_limit(saved_limit), .dma_irq(dma_irq)
  );

  // vector table: initial buffer, next, chain, byte count, expected rounded length
  localparam logic [31:0]    V_INIT  [NV] = '{32'h0, 32'h0500_0000, 32'h0, 32'h0600_0040, 32'h0, 32'h0};
  localparam logic [31:0]    V_NEXT  [NV] = '{32'h0400_0000, 32'h0400_1000, 32'h0400_2000,
                                              32'h0400_3000, 32'h0400_4000, 32'h0400_5000};
  localparam logic           V_CHAIN [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [15:0]    V_BYTES [NV] = '{16'd100, 16'd16, 16'd1, 16'h1FF1, 16'd0, 16'hFFFF};
  localparam logic [16:0]    V_LEN   [NV] = '{17'd112, 17'd16, 17'd16, 17'h2000, 17'd0, 17'h10000};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_burst(input logic [15:0] b);
    @(negedge clk);
    burst_done = 1'b1; burst_bytes = b;
    @(negedge clk);
    burst_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", dma_irq, 0);
    chk("R1 mem_req", mem_req, 0);
    rd(15'h0000, v); chk("R1 ctrl", v, 0);
    rd(15'h4000, v); chk("R1 next", v, 0);
    rd(15'h4200, v); chk("R1 init", v, 0);
    rd(15'h4204, v); chk("R1 size", v, 0);

    // R2 plain register storage
    wr(15'h4204, 32'h1234_5678); rd(15'h4204, v); chk("R2 size", v, 32'h1234_5678);
    wr(15'h4008, 32'hA5A5_0000); rd(15'h4008, v); chk("R2 start", v, 32'hA5A5_0000);
    wr(15'h400C, 32'h0000_5A5A); rd(15'h400C, v); chk("R2 stop", v, 32'h0000_5A5A);

    // R11 unmapped offsets
    wr(15'h4000, 32'h0000_1111);
    wr(15'h4010, 32'hDEAD_BEEF); rd(15'h4010, v); chk("R11 read unmapped", v, 0);
    wr(15'h4001, 32'hCAFE_0000); rd(15'h4000, v); chk("R11 next untouched", v, 32'h0000_1111);

    // R3 command bits
    wr(15'h0000, 32'h0010_0000); rd(15'h0000, v); chk("R3 direction set", v, 32'h8);
    wr(15'h0000, 32'h0000_FFFF); rd(15'h0000, v); chk("R3 no command no effect", v, 32'h8);
    wr(15'h0000, 32'h0003_0000); rd(15'h0000, v); chk("R3 enable+chain", v, 32'hB);
    // R4 reset command, alone and against a set in the same write
    wr(15'h0000, 32'h0008_0000); rd(15'h0000, v); chk("R4 reset clears", v, 32'h0);
    wr(15'h0000, 32'h0019_0000); rd(15'h0000, v); chk("R4 reset beats set", v, 32'h0);

    // R5 disabled channel ignores a burst
    pulse_burst(16'd64);
    chk("R5 no request", mem_req, 0);
    repeat (3) @(negedge clk);
    chk("R5 no request later", mem_req, 0);
    chk("R5 no irq", dma_irq, 0);

    // table walk: R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [31:0] st, sp, lim, base;
      st   = 32'h0800_0000 | (32'(i) << 8);
      sp   = st + 32'h80;
      lim  = V_NEXT[i] + 32'h200;
      base = (V_INIT[i] != 0) ? V_INIT[i] : V_NEXT[i];
      wr(15'h0000, 32'h0008_0000);
      wr(15'h0000, 32'h0001_0000 | (32'(V_CHAIN[i]) << 17));
      wr(15'h4000, V_NEXT[i]);
      wr(15'h4004, lim);
      wr(15'h4008, st);
      wr(15'h400C, sp);
      wr(15'h4200, V_INIT[i]);
      pulse_burst(V_BYTES[i]);
      chk($sformatf("R6 req v%0d", i), mem_req, 1);
      chk($sformatf("R6 addr v%0d", i), mem_addr, base);
      chk($sformatf("R7 len v%0d", i), mem_len, V_LEN[i]);
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      chk($sformatf("R10 irq high v%0d", i), dma_irq, 1);
      chk($sformatf("R12 req drop v%0d", i), mem_req, 0);
      chk($sformatf("R8 saved next v%0d", i), saved_next, V_NEXT[i]);
      chk($sformatf("R8 saved limit v%0d", i), saved_limit, V_NEXT[i] + 32'(V_LEN[i]));
      @(negedge clk);
      chk($sformatf("R10 irq low v%0d", i), dma_irq, 0);
      rd(15'h4200, v); chk($sformatf("R8 init cleared v%0d", i), v, 0);
      rd(15'h4000, v); chk($sformatf("R9 next v%0d", i), v, V_CHAIN[i] ? V_NEXT[i] : st);
      rd(15'h4004, v); chk($sformatf("R9 limit v%0d", i), v, V_CHAIN[i] ? lim : sp);
      rd(15'h0000, v); chk($sformatf("R10 ctrl v%0d", i), v, 32'h5 | (32'(V_CHAIN[i]) << 1));
    end

    // R3 clear-complete leaves the other flags
    wr(15'h0000, 32'h0004_0000); rd(15'h0000, v); chk("R3 clear complete", v, 32'h3);

    // R12 request holds, a report during the wait is dropped
    wr(15'h0000, 32'h0008_0000);
    wr(15'h0000, 32'h0001_0000);
    wr(15'h4000, 32'h0400_9000);
    pulse_burst(16'd32);
    chk("R12 len first", mem_len, 17'd32);
    pulse_burst(16'd200);
    chk("R12 len held", mem_len, 17'd32);
    chk("R12 addr held", mem_addr, 32'h0400_9000);
    repeat (2) @(negedge clk);
    chk("R12 req held", mem_req, 1);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R10 irq busy case", dma_irq, 1);
    repeat (3) @(negedge clk);
    chk("R12 dropped report", mem_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule